// File: doc/BRIEF.md
# Over-Temperature Stage Alarm

This peripheral watches a stream of die-temperature samples, given in whole degrees Celsius with a one-cycle valid strobe. It places each sample on a ladder of three trip points. The ladder's base is moved by a 2-bit threshold offset, and the trip points are 20 degrees apart. A parameter selects one of two variants. The coarse variant (`FINE_STATE=0`) reports a 2-bit stage from 0 to 3. The fine variant (`FINE_STATE=1`) reports a 3-bit state from 0 to 7 that splits every stage into finer steps. Stepping down requires a 2-degree margin of hysteresis. Software reaches the block through a byte-wide register port with an 8-bit offset. The port gives access to identity, status, shutdown-control and alarm-control registers.

A small tracking state machine carries the block's behaviour. Its states are TS_OFF, TS_IDLE and TS_EVAL, and every transition is listed below:
- TS_OFF moves to TS_IDLE on the first clock after the alarm is enabled.
- TS_IDLE moves to TS_EVAL when a sample is accepted.
- TS_EVAL stays in TS_EVAL when another sample arrives during evaluation.
- TS_EVAL returns to TS_IDLE when no sample arrives.
- Every state falls to TS_OFF while the alarm is disabled.

In TS_OFF the level is forced to zero. The level-sensitive interrupt raises whenever the reported value changes. Reading the status register clears it. Two shutdown request outputs follow the upper stages, and each of them can be masked by software.

Top module: `temp_alarm_top`

## Requirements
- R1: Offset 0x04 reads 0x09. Offset 0x05 reads 0x08 in the coarse variant and 0x09 in the fine variant.
- R2: Status at offset 0x08 holds the coarse stage in bits 1:0 (coarse variant) or the fine state in bits 6:4 (fine variant). All other bits read 0.
- R3: Shutdown control at offset 0x40 is read/write:
  - bits 1:0 hold the threshold offset t;
  - bit 6 masks the stage-2 shutdown;
  - bit 7 masks the stage-3 shutdown;
  - bits 5:2 read 0;
  - the register resets to 0x00.
- R4: The trip points are 105+5t, 125+5t and 145+5t. On a rise, the coarse stage equals the number of trip points at or below the sample.
- R5: The fine variant uses seven boundaries: each trip point, each trip point plus 10, and the top trip point plus 20. The fine state counts the boundaries crossed. It maps to the coarse stage as {0,1,1,2,2,3,3,3}.
- R6: The level drops only when the sample is more than 2 degrees below a boundary. The new level is the number of boundaries b with sample >= b-2.
- R7: A sample is taken at a clock edge where the valid strobe is high and the tracker is armed. Status, interrupt and shutdowns reflect that sample one edge later. A sample that arrives during evaluation is also taken.
- R8: Alarm control at offset 0x46 uses only bit 7, the enable, and resets to 0. While the enable is clear:
  - the level is held at 0;
  - the interrupt is low;
  - samples are ignored;
  - the tracker re-arms one edge after the enable is set.
- R9: The stage-2 shutdown output is high while the coarse stage is 2 or more and bit 6 is clear. The stage-3 shutdown output is high while the coarse stage is 3 and bit 7 is clear.
- R10: The interrupt sets when an evaluation changes the reported value. A read of offset 0x08 clears it. If a set and a clear fall in the same cycle, the set wins.
- R11: Unimplemented offsets read 0x00 and ignore writes. Writes to offsets 0x04, 0x05 and 0x08 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_c | input | TEMP_W | Temperature sample, whole degrees C |
| temp_vld | input | 1 | Sample valid strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from offset |
| irq | output | 1 | Level interrupt on change of reported value |
| shdn_stage2 | output | 1 | Stage-2 shutdown request |
| shdn_stage3 | output | 1 | Stage-3 shutdown request |

## Verification
Two functions can fall in the same cycle: an evaluation that changes the level and so sets the interrupt, and a status read that clears it. The bench provokes this case by raising the read strobe at offset 0x08 in exactly the cycle that follows a sample's capture. The case is judged correct only if the interrupt is still high afterwards. The same collision is also reached at random when samples and status reads are interleaved. In every cycle, a behavioural model of both variants is compared against the read data, the interrupt and both shutdown outputs.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;
    localparam logic [7:0] OFS_ID     = 8'h04;
    localparam logic [7:0] OFS_SUB    = 8'h05;
    localparam logic [7:0] OFS_STAT   = 8'h08;
    localparam logic [7:0] OFS_SDCTL  = 8'h40;
    localparam logic [7:0] OFS_ALARM  = 8'h46;
    localparam logic [7:0] ID_VALUE   = 8'h09;
    localparam logic [7:0] SUB_COARSE = 8'h08;
    localparam logic [7:0] SUB_FINE   = 8'h09;
    localparam int         LVL_W      = 3;

    typedef enum logic [1:0] {
        TS_OFF  = 2'd0,
        TS_IDLE = 2'd1,
        TS_EVAL = 2'd2
    } trk_state_t;

    // fine state 0..7 -> coarse stage {0,1,1,2,2,3,3,3}
    function automatic logic [1:0] fine_to_coarse(input logic [LVL_W-1:0] s);
        logic [LVL_W:0] t;
        t = ({1'b0, s} + 4'd1) >> 1;
        if (t > 4'd3) t = 4'd3;
        return t[1:0];
    endfunction
endpackage

// File: rtl/temp_alarm_regs.sv
module temp_alarm_regs
    import temp_alarm_pkg::*;
#(
    parameter int FINE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic [LVL_W-1:0] lvl,
    output logic [7:0]       rdata,
    output logic [1:0]       thresh,
    output logic             ovr2,
    output logic             ovr3,
    output logic             alarm_en,
    output logic             stat_rd
);
    logic [7:0] status_byte;
    logic       unused_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thresh   <= 2'd0;
            ovr2     <= 1'b0;
            ovr3     <= 1'b0;
            alarm_en <= 1'b0;
        end else if (wr) begin
            if (addr == OFS_SDCTL) begin
                thresh <= wdata[1:0];
                ovr2   <= wdata[6];
                ovr3   <= wdata[7];
            end
            if (addr == OFS_ALARM) begin
                alarm_en <= wdata[7];
            end
        end
    end

    generate
        if (FINE != 0) begin : g_fine_stat
            assign status_byte = {1'b0, lvl, 4'b0000};
            assign unused_bits = ^wdata[5:2];
        end else begin : g_coarse_stat
            assign status_byte = {6'b000000, lvl[1:0]};
            assign unused_bits = ^{wdata[5:2], lvl[2]};
        end
    endgenerate

    always_comb begin
        case (addr)
            OFS_ID:    rdata = ID_VALUE;
            OFS_SUB:   rdata = (FINE != 0) ? SUB_FINE : SUB_COARSE;
            OFS_STAT:  rdata = status_byte;
            OFS_SDCTL: rdata = {ovr3, ovr2, 4'b0000, thresh};
            OFS_ALARM: rdata = {alarm_en, 7'b0000000};
            default:   rdata = 8'h00;
        endcase
    end

    assign stat_rd = rd && (addr == OFS_STAT);
endmodule

// File: rtl/temp_alarm_ladder.sv
module temp_alarm_ladder
    import temp_alarm_pkg::*;
#(
    parameter int FINE   = 1,
    parameter int TEMP_W = 8,
    parameter int BASE   = 105,
    parameter int SPAN   = 20,
    parameter int STEP   = 5,
    parameter int HYST   = 2
) (
    input  logic [TEMP_W-1:0] samp,
    input  logic [1:0]        thresh,
    output logic [LVL_W-1:0]  raw_cnt,
    output logic [LVL_W-1:0]  hys_cnt
);
    localparam int NB = (FINE != 0) ? 7 : 3;
    localparam int CW = TEMP_W + 2;

    logic [NB-1:0] above;
    logic [NB-1:0] near;
    logic [CW-1:0] samp_x;

    assign samp_x = {2'b00, samp};

    for (genvar i = 0; i < NB; i++) begin : g_bnd
        localparam int OFS = (FINE != 0) ? (SPAN * (i / 2) + (i % 2) * (SPAN / 2))
                                         : (SPAN * i);
        logic [CW-1:0] bnd;
        assign bnd      = CW'(BASE + OFS) + CW'(STEP) * {{(CW-2){1'b0}}, thresh};
        assign above[i] = samp_x >= bnd;
        assign near[i]  = (samp_x + CW'(HYST)) >= bnd;
    end

    always_comb begin
        raw_cnt = '0;
        hys_cnt = '0;
        for (int k = 0; k < NB; k++) begin
            raw_cnt = raw_cnt + LVL_W'(above[k]);
            hys_cnt = hys_cnt + LVL_W'(near[k]);
        end
    end
endmodule

// File: rtl/temp_alarm_tracker.sv
module temp_alarm_tracker
    import temp_alarm_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              smp_vld,
    input  logic [TEMP_W-1:0] smp_temp,
    input  logic              stat_rd,
    input  logic [LVL_W-1:0]  raw_cnt,
    input  logic [LVL_W-1:0]  hys_cnt,
    output logic [TEMP_W-1:0] held_temp,
    output logic [LVL_W-1:0]  lvl,
    output logic              irq,
    output logic              evaluating
);
    trk_state_t        st_q, st_d;
    logic [TEMP_W-1:0] temp_d;
    logic [LVL_W-1:0]  lvl_d, eval_lvl;
    logic              irq_d, chg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= TS_OFF;
            held_temp <= '0;
            lvl       <= '0;
            irq       <= 1'b0;
        end else begin
            st_q      <= st_d;
            held_temp <= temp_d;
            lvl       <= lvl_d;
            irq       <= irq_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_OFF:  st_d = TS_IDLE;
            TS_IDLE: if (smp_vld) st_d = TS_EVAL;
            TS_EVAL: if (!smp_vld) st_d = TS_IDLE;
            default: st_d = TS_OFF;
        endcase
        if (!en) st_d = TS_OFF;
    end

    always_comb begin
        if (raw_cnt > lvl)      eval_lvl = raw_cnt;
        else if (hys_cnt < lvl) eval_lvl = hys_cnt;
        else                    eval_lvl = lvl;
    end

    // outputs and datapath
    always_comb begin
        temp_d = held_temp;
        lvl_d  = lvl;
        irq_d  = irq;
        chg    = 1'b0;
        if (!en) begin
            lvl_d = '0;
            irq_d = 1'b0;
        end else begin
            unique case (st_q)
                TS_EVAL: begin
                    chg   = (eval_lvl != lvl);
                    lvl_d = eval_lvl;
                    if (smp_vld) temp_d = smp_temp;
                end
                TS_IDLE: if (smp_vld) temp_d = smp_temp;
                default: ;
            endcase
            if (chg)          irq_d = 1'b1;
            else if (stat_rd) irq_d = 1'b0;
        end
    end

    assign evaluating = (st_q == TS_EVAL);
endmodule

// File: rtl/temp_alarm_top.sv
module temp_alarm_top
    import temp_alarm_pkg::*;
#(
    parameter int FINE_STATE    = 1,
    parameter int TEMP_W        = 8,
    parameter int BASE_TRIP_C   = 105,
    parameter int STAGE_SPAN_C  = 20,
    parameter int THRESH_STEP_C = 5,
    parameter int HYST_C        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_c,
    input  logic              temp_vld,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              shdn_stage2,
    output logic              shdn_stage3
);
    logic [1:0]        thresh;
    logic              ovr2, ovr3, alarm_en, stat_rd, evaluating;
    logic [LVL_W-1:0]  lvl, raw_cnt, hys_cnt;
    logic [TEMP_W-1:0] held_temp;
    logic [1:0]        coarse;

    temp_alarm_regs #(.FINE(FINE_STATE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .lvl(lvl), .rdata(reg_rdata), .thresh(thresh),
        .ovr2(ovr2), .ovr3(ovr3), .alarm_en(alarm_en), .stat_rd(stat_rd)
    );

    temp_alarm_ladder #(
        .FINE(FINE_STATE), .TEMP_W(TEMP_W), .BASE(BASE_TRIP_C),
        .SPAN(STAGE_SPAN_C), .STEP(THRESH_STEP_C), .HYST(HYST_C)
    ) u_ladder (
        .samp(held_temp), .thresh(thresh), .raw_cnt(raw_cnt), .hys_cnt(hys_cnt)
    );

    temp_alarm_tracker #(.TEMP_W(TEMP_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .en(alarm_en), .smp_vld(temp_vld),
        .smp_temp(temp_c), .stat_rd(stat_rd), .raw_cnt(raw_cnt),
        .hys_cnt(hys_cnt), .held_temp(held_temp), .lvl(lvl), .irq(irq),
        .evaluating(evaluating)
    );

    generate
        if (FINE_STATE != 0) begin : g_fine_map
            assign coarse = fine_to_coarse(lvl);
        end else begin : g_coarse_map
            assign coarse = lvl[1:0];
        end
    endgenerate

    assign shdn_stage2 = (coarse >= 2'd2) && !ovr2;
    assign shdn_stage3 = (coarse == 2'd3) && !ovr3;
endmodule

// File: rtl/temp_alarm_chk.sv
module temp_alarm_chk
    import temp_alarm_pkg::*;
#(
    parameter int FINE = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alarm_en,
    input logic             evaluating,
    input logic [LVL_W-1:0] lvl,
    input logic             irq,
    input logic             shdn_stage2,
    input logic             shdn_stage3,
    input logic             ovr2,
    input logic             ovr3
);
    logic [1:0] stage_c;
    assign stage_c = (FINE != 0) ? fine_to_coarse(lvl) : lvl[1:0];

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_en |=> (lvl == '0) && !irq);

    assert_change_raises_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl != $past(lvl)) && $past(alarm_en)) |-> irq);

    assert_irq_needs_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (lvl != $past(lvl)));

    assert_hold_outside_eval_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && !evaluating) |=> $stable(lvl));

    assert_no_shdn_below_stage2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_c < 2'd2) |-> !shdn_stage2 && !shdn_stage3);

    assert_masked_shdn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr2 && ovr3) |-> !shdn_stage2 && !shdn_stage3);
endmodule

bind temp_alarm_top temp_alarm_chk #(.FINE(FINE_STATE)) u_chk (
    .clk(clk), .rst_n(rst_n), .alarm_en(alarm_en), .evaluating(evaluating),
    .lvl(lvl), .irq(irq), .shdn_stage2(shdn_stage2), .shdn_stage3(shdn_stage3),
    .ovr2(ovr2), .ovr3(ovr3)
);

// File: tb/tb_temp_alarm_top.sv
module tb_temp_alarm_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] temp_c = 8'd0;
    logic       temp_vld = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_addr = 8'd0, reg_wdata = 8'd0;
    logic [7:0] rdata [2];
    logic       irq_o [2];
    logic       s2_o [2];
    logic       s3_o [2];

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    temp_alarm_top #(.FINE_STATE(0)) dut (
        .clk(clk), .rst_n(rst_n), .temp_c(temp_c), .temp_vld(temp_vld),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata[0]), .irq(irq_o[0]), .shdn_stage2(s2_o[0]), .shdn_stage3(s3_o[0]));

    temp_alarm_top #(.FINE_STATE(1)) dut_fine (
        .clk(clk), .rst_n(rst_n), .temp_c(temp_c), .temp_vld(temp_vld),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata[1]), .irq(irq_o[1]), .shdn_stage2(s2_o[1]), .shdn_stage3(s3_o[1]));

    // ---------------- behavioural reference ----------------
    int m_en, m_thr, m_ovr2, m_ovr3, m_ms, m_samp;
    int m_lvl [2];
    int m_irq [2];
    int stage_map [8] = '{0, 1, 1, 2, 2, 3, 3, 3};

    function automatic int bnd(int v, int i, int thr);
        int ofs = (v != 0) ? 20 * (i / 2) + (i % 2) * 10 : 20 * i;
        return 105 + 5 * thr + ofs;
    endfunction

    function automatic int coarse_of(int v, int l);
        return (v != 0) ? stage_map[l] : l;
    endfunction

    function automatic int exp_rd(int v, logic [7:0] a);
        case (a)
            8'h04: return 9;
            8'h05: return (v != 0) ? 9 : 8;
            8'h08: return (v != 0) ? (m_lvl[v] << 4) : m_lvl[v];
            8'h40: return (m_ovr3 << 7) | (m_ovr2 << 6) | m_thr;
            8'h46: return m_en << 7;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h04, 8'h05: return "R1";
            8'h08: return "R2";
            8'h40: return "R3";
            8'h46: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(int act, int exp, string tag, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int raw, hy, nl, set;
        if (!rst_n) begin
            m_en = 0; m_thr = 0; m_ovr2 = 0; m_ovr3 = 0; m_ms = 0; m_samp = 0;
            for (int v = 0; v < 2; v++) begin m_lvl[v] = 0; m_irq[v] = 0; end
        end else begin
            for (int v = 0; v < 2; v++) begin
                set = 0;
                if (m_en == 0) begin
                    m_lvl[v] = 0; m_irq[v] = 0;
                end else begin
                    if (m_ms == 2) begin
                        raw = 0; hy = 0;
                        for (int i = 0; i < ((v != 0) ? 7 : 3); i++) begin
                            if (m_samp >= bnd(v, i, m_thr)) raw++;
                            if (m_samp + 2 >= bnd(v, i, m_thr)) hy++;
                        end
                        nl = (raw > m_lvl[v]) ? raw : ((hy < m_lvl[v]) ? hy : m_lvl[v]);
                        set = (nl != m_lvl[v]);
                        m_lvl[v] = nl;
                    end
                    if (set != 0) m_irq[v] = 1;
                    else if (reg_rd && reg_addr == 8'h08) m_irq[v] = 0;
                end
            end
            if (m_en == 0) m_ms = 0;
            else if (m_ms == 0) m_ms = 1;
            else if (temp_vld) begin m_samp = temp_c; m_ms = 2; end
            else m_ms = 1;
            if (reg_wr && reg_addr == 8'h40) begin
                m_thr = reg_wdata[1:0]; m_ovr2 = reg_wdata[6]; m_ovr3 = reg_wdata[7];
            end
            if (reg_wr && reg_addr == 8'h46) m_en = reg_wdata[7];
        end
        #2;
        if (rst_n && !done) begin
            for (int v = 0; v < 2; v++) begin
                chk(rdata[v], exp_rd(v, reg_addr), tag_of(reg_addr), "rdata");
                chk(irq_o[v], m_irq[v], "R10", "irq");
                chk(s2_o[v], (coarse_of(v, m_lvl[v]) >= 2 && m_ovr2 == 0) ? 1 : 0, "R9", "shdn2");
                chk(s3_o[v], (coarse_of(v, m_lvl[v]) == 3 && m_ovr3 == 0) ? 1 : 0, "R9", "shdn3");
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, int ec, int ef, string tag);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1;
        chk(rdata[0], ec, tag, "coarse read");
        chk(rdata[1], ef, tag, "fine read");
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic sample(int t);
        @(negedge clk); temp_vld = 1'b1; temp_c = 8'(t);
        @(negedge clk); temp_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic out_chk(int i0, int i1, int a0, int a1, int b0, int b1, string tag);
        chk(irq_o[0], i0, tag, "coarse irq"); chk(irq_o[1], i1, tag, "fine irq");
        chk(s2_o[0], a0, tag, "coarse shdn2"); chk(s2_o[1], a1, tag, "fine shdn2");
        chk(s3_o[0], b0, tag, "coarse shdn3"); chk(s3_o[1], b1, tag, "fine shdn3");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        out_chk(0, 0, 0, 0, 0, 0, "R8");
        rd_chk(8'h46, 0, 0, "R8");
        rd_chk(8'h40, 0, 0, "R3");
        rd_chk(8'h04, 9, 9, "R1");
        rd_chk(8'h05, 8, 9, "R1");
        // disabled: samples ignored
        sample(150);
        rd_chk(8'h08, 0, 0, "R8");
        wr(8'h46, 8'hFF);
        rd_chk(8'h46, 8'h80, 8'h80, "R8");
        wr(8'h40, 8'h00);
        // rising ladder, threshold 0
        sample(104); rd_chk(8'h08, 0, 8'h00, "R4");
        sample(105);
        out_chk(1, 1, 0, 0, 0, 0, "R10");
        rd_chk(8'h08, 1, 8'h10, "R4");
        out_chk(0, 0, 0, 0, 0, 0, "R10");
        sample(115); rd_chk(8'h08, 1, 8'h20, "R5");
        sample(125);
        out_chk(1, 1, 1, 1, 0, 0, "R9");
        rd_chk(8'h08, 2, 8'h30, "R4");
        sample(145); rd_chk(8'h08, 3, 8'h50, "R4");
        out_chk(0, 0, 1, 1, 1, 1, "R9");
        // hysteresis
        sample(143); rd_chk(8'h08, 3, 8'h50, "R6");
        sample(142); rd_chk(8'h08, 2, 8'h40, "R6");
        // latency of one edge after capture
        @(negedge clk); temp_vld = 1'b1; temp_c = 8'd150;
        @(posedge clk); #2; chk(s3_o[0], 0, "R7", "coarse shdn3 before eval");
        chk(s3_o[1], 0, "R7", "fine shdn3 before eval");
        @(negedge clk); temp_vld = 1'b0;
        @(posedge clk); #2; chk(s3_o[0], 1, "R7", "coarse shdn3 after eval");
        chk(s3_o[1], 1, "R7", "fine shdn3 after eval");
        // overrides and threshold field
        wr(8'h40, 8'hC0);
        @(negedge clk); out_chk(irq_o[0], irq_o[1], 0, 0, 0, 0, "R9");
        rd_chk(8'h40, 8'hC0, 8'hC0, "R3");
        wr(8'h40, 8'hFF);
        rd_chk(8'h40, 8'hC3, 8'hC3, "R3");
        wr(8'h40, 8'h03);
        sample(181); rd_chk(8'h08, 3, 8'h70, "R5");
        // unimplemented offsets and read-only registers
        wr(8'h10, 8'h55); rd_chk(8'h10, 0, 0, "R11");
        wr(8'h04, 8'h00); rd_chk(8'h04, 9, 9, "R11");
        wr(8'h08, 8'hFF); rd_chk(8'h08, 3, 8'h70, "R11");
        // set and clear of irq in the same cycle: set wins
        @(negedge clk); temp_vld = 1'b1; temp_c = 8'd100;
        @(negedge clk); temp_vld = 1'b0; reg_rd = 1'b1; reg_addr = 8'h08;
        @(negedge clk); reg_rd = 1'b0;
        out_chk(1, 1, 0, 0, 0, 0, "R10");
        // disable while at a high stage
        sample(181);
        wr(8'h46, 8'h00);
        @(negedge clk);
        out_chk(0, 0, 0, 0, 0, 0, "R8");
        rd_chk(8'h08, 0, 0, "R8");
        sample(181); rd_chk(8'h08, 0, 0, "R8");
        // back-to-back samples after re-enable
        wr(8'h46, 8'h80); wr(8'h40, 8'h00);
        @(negedge clk);
        @(negedge clk); temp_vld = 1'b1; temp_c = 8'd130;
        @(negedge clk); temp_c = 8'd104;
        @(negedge clk); temp_vld = 1'b0;
        @(negedge clk);
        rd_chk(8'h08, 1, 8'h10, "R7");
        // random interleaving judged by the reference model
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            seed = seed * 32'd1664525 + 32'd1013904223;
            temp_vld  = seed[3];
            temp_c    = 8'(90 + (seed[31:24] % 100));
            reg_rd    = seed[5] & seed[6];
            reg_wr    = (seed[9:7] == 3'd0);
            case (seed[12:10])
                3'd0, 3'd1, 3'd2: reg_addr = 8'h08;
                3'd3: reg_addr = 8'h40;
                3'd4: reg_addr = 8'h46;
                3'd5: reg_addr = 8'h05;
                default: reg_addr = 8'h33;
            endcase
            reg_wdata = (reg_addr == 8'h46) ? {~(seed[15] & seed[16]), 7'd0} : seed[23:16];
        end
        @(negedge clk); reg_rd = 1'b0; reg_wr = 1'b0; temp_vld = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule